// File: doc/BRIEF.md
# Pin Port Controller with Atomic Output Updates

This block is a 32-pin general-purpose I/O port seen by software through a small word-addressed register bus. The driven output levels are never written directly. Software hands the block a bit mask through one of three write-only strobes, and the block sets, clears or inverts exactly the masked bits in one cycle. Because of this, two agents that own different pins never need a read-modify-write sequence. Each pin also has a direction bit, which drives the pad's output enable, and a synchronized input level that can be read back as one word.

Every pin has a detector. It can watch for a rising edge, a falling edge, either edge, a high level or a low level, and a detection raises that pin's sticky flag. Software clears a flag by writing a 1 to its bit position. A pin can instead be placed in DMA mode: its flag then appears on a per-pin DMA request line rather than on the shared interrupt line, and the flag drops when the DMA engine returns a completion pulse for that pin. A level-sensitive condition that is still true keeps its flag set through any clear.

Top module: `pinport_top`

## Requirements
- R1: A write to word offset 1 (set strobe) forces to 1 every output bit whose data bit is 1 and leaves the other output bits unchanged, visible on `pin_o` the cycle after the write.
- R2: A write to word offset 2 (clear strobe) forces to 0 every output bit whose data bit is 1 and leaves the other output bits unchanged.
- R3: A write to word offset 3 (invert strobe) inverts every output bit whose data bit is 1. Offsets 1, 2 and 3 read as 0.
- R4: Word offset 0 reads the output register, whose reset value is 0. A write to offset 0 does not change the outputs, and the outputs change only through offsets 1 to 3.
- R5: Word offset 4 is the read/write direction register, with bit n = 1 making pin n an output. It drives `pin_oe` directly and resets to 0 (all inputs).
- R6: Word offset 5 returns all pin levels with bit n = pin n, after a two-flop synchronizer. A level driven on `pin_i` is returned by a read issued two or more cycles later and not by a read issued in the next cycle. Read data appears one cycle after `bus_rd`.
- R7: The trigger mode of pin n is {bit n of offset 10, bit n of offset 9, bit n of offset 8}. Code 1 flags a rising edge, code 2 a falling edge and code 3 either edge, where an edge is a change between consecutive synchronized samples. Codes 0, 6 and 7 never flag.
- R8: Code 4 flags while the synchronized level is high and code 5 while it is low. A flag whose level condition still holds remains set after a clear.
- R9: Word offset 6 reads the per-pin flags with bit n = pin n. Writing 1 to a bit clears that flag, and writing 0 leaves the flag unchanged.
- R10: When a new detection and a clear write hit the same flag in the same cycle, the flag is set afterwards.
- R11: Bit n of offset 11 puts pin n in DMA mode. `dma_req[n]` then shows flag n, and a `dma_done[n]` pulse clears that flag. `dma_done` has no effect on pins that are not in DMA mode.
- R12: `irq_o` is high exactly when some pin not in DMA mode has its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Word offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data or mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_i | input | 32 | Asynchronous pad input levels |
| pin_o | output | 32 | Driven output levels |
| pin_oe | output | 32 | Per-pin output enable (direction) |
| dma_done | input | 32 | Per-pin DMA completion pulse |
| dma_req | output | 32 | Per-pin DMA request |
| irq_o | output | 1 | Combined interrupt from pins not in DMA mode |

## Verification
The two functions that can fall in the same cycle are a software clear of a flag and a new detection on the same pin. The bench sets a flag on an either-edge pin and then moves the pin back. It times the clear write so that the write is sampled on exactly the clock edge at which the synchronized falling edge is detected. The flag must read as set afterwards, and a later clear that has no collision must make it read as 0.

// File: rtl/pinport_pkg.sv
// Package: shared register offsets and trigger-mode codes for the pin port.
// Assumes a word-addressed register bus with a 4-bit offset.
package pinport_pkg;
    localparam int unsigned OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_OUT   = 4'd0;
    localparam logic [OFS_W-1:0] OFS_SET   = 4'd1;
    localparam logic [OFS_W-1:0] OFS_CLR   = 4'd2;
    localparam logic [OFS_W-1:0] OFS_INV   = 4'd3;
    localparam logic [OFS_W-1:0] OFS_DIR   = 4'd4;
    localparam logic [OFS_W-1:0] OFS_LEVEL = 4'd5;
    localparam logic [OFS_W-1:0] OFS_FLAG  = 4'd6;
    localparam logic [OFS_W-1:0] OFS_TRG0  = 4'd8;
    localparam logic [OFS_W-1:0] OFS_TRG1  = 4'd9;
    localparam logic [OFS_W-1:0] OFS_TRG2  = 4'd10;
    localparam logic [OFS_W-1:0] OFS_DMAEN = 4'd11;

    localparam logic [2:0] TRG_RISE = 3'd1;
    localparam logic [2:0] TRG_FALL = 3'd2;
    localparam logic [2:0] TRG_ANY  = 3'd3;
    localparam logic [2:0] TRG_HIGH = 3'd4;
    localparam logic [2:0] TRG_LOW  = 3'd5;
endpackage

// File: rtl/pinport_sync.sv
// Module: two-flop synchronizer for every pin, plus one more stage holding
// the previous synchronized sample for edge detection.
// Assumes pin_i is asynchronous to clk; each bit is synchronized on its own.
module pinport_sync #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] cur_o,
    output logic [NPINS-1:0] prev_o
);
    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;
    logic [1:0]       settle_q;

    // Synchronizer chain and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Counts edges since reset so the checks below skip the first cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)               settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    assign cur_o  = sync_q;
    assign prev_o = prev_q;

    // R6: the synchronized level is the pin level from two edges earlier.
    assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == 2'd3) |-> (sync_q == $past(pin_i, 2)));
endmodule

// File: rtl/pinport_detect.sv
// Module: per-pin trigger decoder that turns the current and previous
// synchronized samples into a one-cycle detection for the selected mode.
// Assumes the mode is held in three bit-planes; unknown codes never fire.
module pinport_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [NPINS-1:0] trg0_i,
    input  logic [NPINS-1:0] trg1_i,
    input  logic [NPINS-1:0] trg2_i,
    output logic [NPINS-1:0] hit_o
);
    import pinport_pkg::*;

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        logic [2:0] code;
        assign code = {trg2_i[n], trg1_i[n], trg0_i[n]};
        // Decode one pin's trigger mode into its detection.
        always_comb begin
            case (code)
                TRG_RISE: hit_o[n] =  cur_i[n] & ~prev_i[n];
                TRG_FALL: hit_o[n] = ~cur_i[n] &  prev_i[n];
                TRG_ANY:  hit_o[n] =  cur_i[n] ^  prev_i[n];
                TRG_HIGH: hit_o[n] =  cur_i[n];
                TRG_LOW:  hit_o[n] = ~cur_i[n];
                default:  hit_o[n] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pinport_flags.sv
// Module: sticky per-pin flag bank. It is set by detections, cleared by
// write-one masks and, for pins in DMA mode, by completion pulses.
// Assumes clr_i is already qualified by a write to the flag offset.
module pinport_flags #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit_i,
    input  logic [NPINS-1:0] clr_i,
    input  logic [NPINS-1:0] dma_en_i,
    input  logic [NPINS-1:0] dma_done_i,
    output logic [NPINS-1:0] flags_o
);
    logic [NPINS-1:0] flags_q;
    logic [NPINS-1:0] drop;

    assign drop = clr_i | (dma_en_i & dma_done_i);

    // Flag update: clears first, then a detection in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~drop) | hit_i;
    end

    assign flags_o = flags_q;

    // R7: a flag becomes set only after a detection on its pin.
    assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & ~$past(flags_q) & ~$past(hit_i)) == '0);
    // R10: a detection always leaves the flag set, even with a clear.
    assert_hit_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_q & $past(hit_i)) == $past(hit_i)));
    // R11: completion on a DMA pin with no new detection drops the flag.
    assert_dma_done_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_q & $past(dma_en_i & dma_done_i & ~hit_i)) == '0));
    // R9: a flag that sees no clear and no completion holds its value.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((~flags_q & $past(flags_q & ~drop)) == '0));
endmodule

// File: rtl/pinport_top.sv
// Module: pin port register block. It decodes the bus, holds the output,
// direction, trigger and DMA-mode registers, and ties the synchronizer,
// detector and flag bank together.
// Assumes single-cycle write strobes and read data returned one cycle later.
module pinport_top #(
    parameter int unsigned NPINS = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [pinport_pkg::OFS_W-1:0]  bus_addr,
    input  logic                           bus_wr,
    input  logic [NPINS-1:0]               bus_wdata,
    input  logic                           bus_rd,
    output logic [NPINS-1:0]               bus_rdata,
    input  logic [NPINS-1:0]               pin_i,
    output logic [NPINS-1:0]               pin_o,
    output logic [NPINS-1:0]               pin_oe,
    input  logic [NPINS-1:0]               dma_done,
    output logic [NPINS-1:0]               dma_req,
    output logic                           irq_o
);
    import pinport_pkg::*;

    logic [NPINS-1:0] out_q, dir_q, trg0_q, trg1_q, trg2_q, dma_en_q;
    logic [NPINS-1:0] cur, prev, hit, flags, flag_clr;
    logic [NPINS-1:0] rdata_q;
    logic wr_set, wr_clr, wr_inv, wr_out_any;

    assign wr_set     = bus_wr && (bus_addr == OFS_SET);
    assign wr_clr     = bus_wr && (bus_addr == OFS_CLR);
    assign wr_inv     = bus_wr && (bus_addr == OFS_INV);
    assign wr_out_any = wr_set | wr_clr | wr_inv;
    assign flag_clr   = (bus_wr && (bus_addr == OFS_FLAG)) ? bus_wdata : '0;

    // Output register: changed only through the set, clear and invert strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_set) out_q <= out_q | bus_wdata;
        else if (wr_clr) out_q <= out_q & ~bus_wdata;
        else if (wr_inv) out_q <= out_q ^ bus_wdata;
    end

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            trg0_q   <= '0;
            trg1_q   <= '0;
            trg2_q   <= '0;
            dma_en_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DIR:   dir_q    <= bus_wdata;
                OFS_TRG0:  trg0_q   <= bus_wdata;
                OFS_TRG1:  trg1_q   <= bus_wdata;
                OFS_TRG2:  trg2_q   <= bus_wdata;
                OFS_DMAEN: dma_en_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Registered read mux; strobe-only and unused offsets return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                OFS_OUT:   rdata_q <= out_q;
                OFS_DIR:   rdata_q <= dir_q;
                OFS_LEVEL: rdata_q <= cur;
                OFS_FLAG:  rdata_q <= flags;
                OFS_TRG0:  rdata_q <= trg0_q;
                OFS_TRG1:  rdata_q <= trg1_q;
                OFS_TRG2:  rdata_q <= trg2_q;
                OFS_DMAEN: rdata_q <= dma_en_q;
                default:   rdata_q <= '0;
            endcase
        end
    end

    pinport_sync #(.NPINS(NPINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur), .prev_o(prev));

    pinport_detect #(.NPINS(NPINS)) detect_i (
        .cur_i(cur), .prev_i(prev), .trg0_i(trg0_q), .trg1_i(trg1_q),
        .trg2_i(trg2_q), .hit_o(hit));

    pinport_flags #(.NPINS(NPINS)) flags_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(flag_clr),
        .dma_en_i(dma_en_q), .dma_done_i(dma_done), .flags_o(flags));

    assign bus_rdata = rdata_q;
    assign pin_o     = out_q;
    assign pin_oe    = dir_q;
    assign dma_req   = flags & dma_en_q;
    assign irq_o     = |(flags & ~dma_en_q);

    // R1: after a set strobe every masked output bit is high.
    assert_set_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_set)) |-> ((pin_o & $past(bus_wdata)) == $past(bus_wdata)));
    // R2: after a clear strobe every masked output bit is low.
    assert_clr_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_clr)) |-> ((pin_o & $past(bus_wdata)) == '0));
    // R3: after an invert strobe the outputs differ exactly in the mask.
    assert_inv_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_inv)) |-> ((pin_o ^ $past(pin_o)) == $past(bus_wdata)));
    // R4: without a strobe the outputs hold.
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_out_any)) |-> $stable(pin_o));
    // R11: a pin not in DMA mode never raises a DMA request.
    assert_req_only_dma_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req & ~dma_en_q) == '0);
endmodule

// File: tb/pinport_top_tb_top.sv
// Bench: sweeps over the output strobes, direction, input levels, every
// trigger code, flag clearing, the clear/detect collision and DMA mode.
// Expected values come from a shadow model kept in the bench.
module pinport_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_i = '0;
    logic [31:0] pin_o, pin_oe, dma_req;
    logic [31:0] dma_done = '0;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pinport_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .dma_done(dma_done),
        .dma_req(dma_req), .irq_o(irq_o));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd, shadow, mask, t0, t1, t2, expv;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R4 R5: reset state.
        check("R4 reset out", pin_o, 32'h0);
        check("R5 reset dir", pin_oe, 32'h0);
        check("R12 reset irq", {31'b0, irq_o}, 32'h0);

        // R1 R2 R3: strobe sweep against the shadow model.
        shadow = '0;
        for (int k = 0; k < 24; k++) begin
            mask = (32'h9E3779B9 * (k + 1)) ^ (32'h1 << k);
            case (k % 3)
                0: begin wr_reg(4'd1, mask); shadow = shadow | mask;  end
                1: begin wr_reg(4'd2, mask); shadow = shadow & ~mask; end
                default: begin wr_reg(4'd3, mask); shadow = shadow ^ mask; end
            endcase
            check((k % 3 == 0) ? "R1 set" : (k % 3 == 1) ? "R2 clear" : "R3 invert", pin_o, shadow);
        end
        rd_reg(4'd0, rd);
        check("R4 read out", rd, shadow);
        rd_reg(4'd1, rd);
        check("R3 strobe reads zero", rd, 32'h0);
        // R4: a direct write to offset 0 has no effect.
        wr_reg(4'd0, ~shadow);
        check("R4 direct write ignored", pin_o, shadow);

        // R5: direction sweep.
        for (int k = 0; k < 8; k++) begin
            mask = 32'h0F0F_3355 << k | (32'h1 << (31 - k));
            wr_reg(4'd4, mask);
            check("R5 oe", pin_oe, mask);
            rd_reg(4'd4, rd);
            check("R5 readback", rd, mask);
        end

        // R6: walking input levels and exact sync latency.
        for (int k = 0; k < 32; k++) begin
            pin_i = (k % 2 == 0) ? (32'h1 << k) : ~(32'h1 << k);
            idle(3);
            rd_reg(4'd5, rd);
            check("R6 level", rd, pin_i);
        end
        @(negedge clk);
        pin_i = 32'hA5A5_5A5A;
        rd_reg(4'd5, rd);
        check("R6 too early", rd, ~(32'h1 << 31));
        @(negedge clk);
        pin_i = 32'h0;
        idle(1);
        rd_reg(4'd5, rd);
        check("R6 after two", rd, 32'h0);
        idle(3);

        // R7 R8: sweep all eight trigger codes, one pin per code.
        for (int m = 0; m < 8; m++) begin
            int p;
            logic ea, eb, ec, ed;
            p = 4 * m + 1;
            t0 = (m & 1) ? (32'h1 << p) : 32'h0;
            t1 = (m & 2) ? (32'h1 << p) : 32'h0;
            t2 = (m & 4) ? (32'h1 << p) : 32'h0;
            wr_reg(4'd8, t0); wr_reg(4'd9, t1); wr_reg(4'd10, t2);
            idle(4);
            wr_reg(4'd6, 32'hFFFF_FFFF);
            ea = (m == 1) || (m == 3) || (m == 4) || (m == 5);
            eb = (m == 4);
            ec = (m >= 2) && (m <= 5);
            ed = (m == 5);
            @(negedge clk); pin_i = 32'h1 << p;
            idle(6);
            rd_reg(4'd6, rd);
            check((m == 4 || m == 5) ? "R8 high/low before clear" : "R7 rising", rd, {31'b0, ea} << p);
            check("R12 irq follows flag", {31'b0, irq_o}, {31'b0, ea});
            wr_reg(4'd6, 32'hFFFF_FFFF);
            idle(2);
            rd_reg(4'd6, rd);
            check("R8 high persists", rd, {31'b0, eb} << p);
            @(negedge clk); pin_i = 32'h0;
            idle(6);
            rd_reg(4'd6, rd);
            check("R7 falling", rd, {31'b0, ec} << p);
            wr_reg(4'd6, 32'hFFFF_FFFF);
            idle(2);
            rd_reg(4'd6, rd);
            check("R8 low persists", rd, {31'b0, ed} << p);
            wr_reg(4'd8, 0); wr_reg(4'd9, 0); wr_reg(4'd10, 0);
            idle(1);
            wr_reg(4'd6, 32'hFFFF_FFFF);
        end

        // R9: zero writes and unrelated bits leave a flag alone.
        wr_reg(4'd8, 32'h1 << 12);
        @(negedge clk); pin_i = 32'h1 << 12;
        idle(6);
        wr_reg(4'd6, 32'h0);
        rd_reg(4'd6, rd);
        check("R9 zero write no effect", rd, 32'h1 << 12);
        wr_reg(4'd6, ~(32'h1 << 12));
        rd_reg(4'd6, rd);
        check("R9 other bits no effect", rd, 32'h1 << 12);
        wr_reg(4'd6, 32'h1 << 12);
        rd_reg(4'd6, rd);
        check("R9 one clears", rd, 32'h0);
        @(negedge clk); pin_i = 32'h0;
        wr_reg(4'd8, 32'h0);
        idle(4);

        // R10: clear sampled on the same edge as a new falling detection.
        wr_reg(4'd8, 32'h1 << 3); wr_reg(4'd9, 32'h1 << 3);
        @(negedge clk); pin_i = 32'h1 << 3;
        idle(6);
        rd_reg(4'd6, rd);
        check("R10 setup flag", rd, 32'h1 << 3);
        @(negedge clk); pin_i = 32'h0;
        @(negedge clk);
        wr_reg(4'd6, 32'h1 << 3);
        rd_reg(4'd6, rd);
        check("R10 detection wins", rd, 32'h1 << 3);
        wr_reg(4'd6, 32'h1 << 3);
        rd_reg(4'd6, rd);
        check("R10 later clear works", rd, 32'h0);
        wr_reg(4'd8, 0); wr_reg(4'd9, 0);

        // R11 R12: DMA pin 7 and interrupt pin 9, both rising.
        wr_reg(4'd8, (32'h1 << 7) | (32'h1 << 9));
        wr_reg(4'd11, 32'h1 << 7);
        @(negedge clk); pin_i = 32'h1 << 7;
        idle(6);
        check("R11 dma request", dma_req, 32'h1 << 7);
        check("R12 dma pin no irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk); pin_i = (32'h1 << 7) | (32'h1 << 9);
        idle(6);
        check("R12 irq from pin 9", {31'b0, irq_o}, 32'h1);
        check("R11 no request pin 9", dma_req, 32'h1 << 7);
        @(negedge clk); dma_done = 32'h1 << 9;
        @(negedge clk); dma_done = 32'h0;
        rd_reg(4'd6, rd);
        check("R11 done ignored on non-dma pin", rd, (32'h1 << 7) | (32'h1 << 9));
        @(negedge clk); dma_done = 32'h1 << 7;
        @(negedge clk); dma_done = 32'h0;
        expv = 32'h1 << 9;
        rd_reg(4'd6, rd);
        check("R11 done clears", rd, expv);
        check("R11 request drops", dma_req, 32'h0);
        check("R12 irq stays", {31'b0, irq_o}, 32'h1);
        wr_reg(4'd6, 32'h1 << 9);
        idle(1);
        check("R12 irq drops", {31'b0, irq_o}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule